// File: doc/BRIEF.md
# Per-Line Configurable Interrupt Collector

This block watches sixteen already-synchronized input lines and turns selected conditions on them into a single active-high interrupt request for a parent controller. Each line can be set to sense a level (high or low), a single edge (rising or falling) or both edges. Three per-line configuration bits select the trigger: a sense-kind bit (0 = level, 1 = edge), a both-edges bit and a polarity bit. Edge events are held in a per-line event latch until software clears them. Level lines report their live condition.

Software reaches the block through a small register window. It has 16-bit data, byte offsets and a combinational read path. The window holds write-one-to-clear acknowledge, an acknowledge that also masks the line, the three configuration vectors, the mask vector and the pending vector. The interrupt output is the OR of all pending lines. The external reset is asynchronous and active-low. Its release is synchronized inside the block over two clock edges.

Top module: `line_event_irq`

## Requirements
- R1: After reset, every mask bit is 1 and the sense-kind, both-edges and polarity vectors read 0. Pending reads 0 and `irq_out` is low.
- R2: Writes to offsets 0x4 (sense kind), 0x6 (both edges), 0x8 (polarity) and 0xA (mask) store all 16 bits, and reads at the same offsets return them. Bit n always belongs to line n.
- R3: A line with sense kind 0 is pending in the same cycle while its input equals its polarity bit (1 = high, 0 = low) and it is unmasked. An acknowledge does not clear it while the condition holds.
- R4: A line with sense kind 1 and both-edges 0 latches an event when its input changes from the previous cycle's value toward the polarity value (polarity 1 = rising, 0 = falling). The event stays latched after the input returns.
- R5: A line with sense kind 1 and both-edges 1 latches an event on any change of its input, whatever its polarity bit holds.
- R6: Writing to offset 0x0 clears the latched event of every line whose data bit is 1. Lines written with 0 keep their events.
- R7: Writing to offset 0x2 clears the latched events of the lines written with 1 and sets their mask bits. All other mask bits are left unchanged.
- R8: An edge that arrives in the same cycle as an acknowledge of that line stays latched.
- R9: Reading offset 0xC returns the pending vector. For edge lines this is the latched event AND NOT mask. Events still latch while a line is masked and show once it is unmasked. A line in level mode holds no latched event.
- R10: `irq_out` is 1 exactly when the pending vector is nonzero, in the same cycle.
- R11: Writes to 0xC, 0xE and odd offsets change nothing. Reads of 0x0, 0x2, 0xE and odd offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 16 | Synchronized line levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` |
| irq_out | output | 1 | Combined interrupt request, active high |

## Verification
The case hardest to reach from the ports is an edge arriving in the very cycle that software acknowledges the same line. A related case is an event latched while a line is masked, which must surface only once the line is unmasked. Directed sequences line both of these up exactly, and also cover mode switches that discard latched events. A long seeded random run then overlays sparse line toggles on random writes to every offset, legal or not. It compares the read data and the interrupt output on every cycle against a reference model in the bench.

// File: rtl/line_event_irq_pkg.sv
package line_event_irq_pkg;
  localparam int ADDR_W = 4;
  // Byte offsets inside the register window
  localparam logic [ADDR_W-1:0] OFS_ACK     = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_ACK_MSK = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_KIND    = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_BOTH    = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_POL     = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 4'hA;
  localparam logic [ADDR_W-1:0] OFS_PEND    = 4'hC;
endpackage

// File: rtl/line_event_irq_cfg.sv
module line_event_irq_cfg
  import line_event_irq_pkg::*;
#(
  parameter int N_LINES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [N_LINES-1:0]  wdata,
  output logic [N_LINES-1:0]  kind_q,
  output logic [N_LINES-1:0]  both_q,
  output logic [N_LINES-1:0]  pol_q,
  output logic [N_LINES-1:0]  mask_q,
  output logic [N_LINES-1:0]  ack_vec
);
  logic [N_LINES-1:0] kind_d, both_d, pol_d, mask_d;

  always_comb begin
    kind_d  = kind_q;
    both_d  = both_q;
    pol_d   = pol_q;
    mask_d  = mask_q;
    ack_vec = '0;
    if (wr_en) begin
      unique case (addr)
        OFS_ACK:     ack_vec = wdata;
        OFS_ACK_MSK: begin
          ack_vec = wdata;
          mask_d  = mask_q | wdata;
        end
        OFS_KIND:    kind_d = wdata;
        OFS_BOTH:    both_d = wdata;
        OFS_POL:     pol_d  = wdata;
        OFS_MASK:    mask_d = wdata;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      both_q <= '0;
      pol_q  <= '0;
      mask_q <= '1;
    end else begin
      kind_q <= kind_d;
      both_q <= both_d;
      pol_q  <= pol_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/line_event_irq_cell.sv
module line_event_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic kind,
  input  logic both,
  input  logic pol,
  input  logic mask,
  input  logic ack,
  output logic pend,
  output logic prev_q,
  output logic latch_q
);
  logic rise, fall, evt, set_ev, latch_d, level_hit;

  always_comb begin
    rise      = line & ~prev_q;
    fall      = ~line & prev_q;
    evt       = both ? (rise | fall) : (pol ? rise : fall);
    set_ev    = kind & evt;
    // a fresh edge wins over a same-cycle acknowledge
    latch_d   = kind & (set_ev | (latch_q & ~ack));
    level_hit = ~kind & (line == pol);
    pend      = ~mask & ((kind & latch_q) | level_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= line;
      latch_q <= latch_d;
    end
  end
endmodule

// File: rtl/line_event_irq_rdmux.sv
module line_event_irq_rdmux
  import line_event_irq_pkg::*;
#(
  parameter int N_LINES = 16
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [N_LINES-1:0] kind,
  input  logic [N_LINES-1:0] both,
  input  logic [N_LINES-1:0] pol,
  input  logic [N_LINES-1:0] mask,
  input  logic [N_LINES-1:0] pend,
  output logic [N_LINES-1:0] rdata
);
  always_comb begin
    unique case (addr)
      OFS_KIND: rdata = kind;
      OFS_BOTH: rdata = both;
      OFS_POL:  rdata = pol;
      OFS_MASK: rdata = mask;
      OFS_PEND: rdata = pend;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/line_event_irq.sv
module line_event_irq
  import line_event_irq_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LINES-1:0]  line_in,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [N_LINES-1:0]  wdata,
  output logic [N_LINES-1:0]  rdata,
  output logic                irq_out
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;
  logic [N_LINES-1:0]     kind_q, both_q, pol_q, mask_q, ack_vec;
  logic [N_LINES-1:0]     pend_vec, prev_vec, latch_vec;

  // reset asserts at once, releases after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  line_event_irq_cfg #(.N_LINES(N_LINES)) u_cfg (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .kind_q(kind_q), .both_q(both_q), .pol_q(pol_q), .mask_q(mask_q),
    .ack_vec(ack_vec)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    line_event_irq_cell u_cell (
      .clk(clk), .rst_n(rst_core_n), .line(line_in[g]),
      .kind(kind_q[g]), .both(both_q[g]), .pol(pol_q[g]),
      .mask(mask_q[g]), .ack(ack_vec[g]),
      .pend(pend_vec[g]), .prev_q(prev_vec[g]), .latch_q(latch_vec[g])
    );
  end

  line_event_irq_rdmux #(.N_LINES(N_LINES)) u_rdmux (
    .addr(addr), .kind(kind_q), .both(both_q), .pol(pol_q),
    .mask(mask_q), .pend(pend_vec), .rdata(rdata)
  );

  assign irq_out = |pend_vec;
endmodule

// File: rtl/line_event_irq_chk.sv
module line_event_irq_chk
  import line_event_irq_pkg::*;
#(
  parameter int N_LINES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] line_in,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [N_LINES-1:0] wdata,
  input logic               irq_out,
  input logic [N_LINES-1:0] kind,
  input logic [N_LINES-1:0] both,
  input logic [N_LINES-1:0] pol,
  input logic [N_LINES-1:0] mask,
  input logic [N_LINES-1:0] prev,
  input logic [N_LINES-1:0] latch
);
  logic [N_LINES-1:0] evt_bits;
  always_comb
    evt_bits = kind & ((both & (line_in ^ prev)) |
                       (~both & pol & line_in & ~prev) |
                       (~both & ~pol & ~line_in & prev));

  // R1
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq_out);
  // R4
  edge_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_bits != '0) |=> ((latch & $past(evt_bits)) == $past(evt_bits)));
  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_ACK) |=> ((latch & $past(wdata & ~evt_bits)) == '0));
  // R7
  ack_mask_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_ACK_MSK) |=> ((mask & $past(wdata)) == $past(wdata)));
  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MASK) |=> (mask == $past(wdata)));
  // R11
  pend_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_PEND) |=> ($stable(mask) && $stable(kind) &&
                                     $stable(both) && $stable(pol)));
endmodule

bind line_event_irq line_event_irq_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .line_in(line_in), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .irq_out(irq_out), .kind(kind_q),
  .both(both_q), .pol(pol_q), .mask(mask_q), .prev(prev_vec),
  .latch(latch_vec)
);

// File: tb/line_event_irq_bench.sv
`timescale 1ns/1ps
module line_event_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] line_in;
  logic        wr_en;
  logic [3:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [15:0] m_kind, m_both, m_pol, m_mask, m_latch, m_prev;

  always #2.5 clk = ~clk;

  line_event_irq u_line_event_irq (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  function automatic logic [15:0] exp_pend(logic [15:0] ln);
    return ((m_kind & m_latch) | (~m_kind & ~(ln ^ m_pol))) & ~m_mask;
  endfunction

  function automatic logic [15:0] exp_rd(logic [3:0] a, logic [15:0] ln);
    case (a)
      4'h4: return m_kind;
      4'h6: return m_both;
      4'h8: return m_pol;
      4'hA: return m_mask;
      4'hC: return exp_pend(ln);
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_kind = '0; m_both = '0; m_pol = '0; m_mask = '1; m_latch = '0; m_prev = '0;
  endtask

  task automatic step(string tag, logic [15:0] ln, bit wr, logic [3:0] a, logic [15:0] d);
    logic [15:0] rise, fall, ev, ack;
    @(negedge clk);
    line_in = ln; wr_en = wr; addr = a; wdata = d;
    #1;
    check(tag, rdata, exp_rd(a, ln));
    check("R10", {15'h0, irq_out}, {15'h0, |exp_pend(ln)});
    @(posedge clk);
    rise = ln & ~m_prev;
    fall = ~ln & m_prev;
    ev   = (m_both & (rise | fall)) | (~m_both & ((m_pol & rise) | (~m_pol & fall)));
    ack  = (wr && (a == 4'h0 || a == 4'h2)) ? d : 16'h0;
    m_latch = m_kind & ((m_kind & ev) | (m_latch & ~ack));
    m_prev  = ln;
    if (wr) begin
      case (a)
        4'h2: m_mask = m_mask | d;
        4'h4: m_kind = d;
        4'h6: m_both = d;
        4'h8: m_pol  = d;
        4'hA: m_mask = d;
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] ln;
    rst_n = 1'b0; line_in = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state through every readable offset
    step("R1", 16'h0, 0, 4'h4, 0);
    step("R1", 16'h0, 0, 4'h6, 0);
    step("R1", 16'h0, 0, 4'h8, 0);
    step("R1", 16'h0, 0, 4'hA, 0);
    step("R1", 16'hFFFF, 0, 4'hC, 0);

    // R2: configuration write and readback
    step("R2", 16'h0, 1, 4'h4, 16'hA5A5);
    step("R2", 16'h0, 1, 4'h6, 16'h3C3C);
    step("R2", 16'h0, 1, 4'h8, 16'h0FF0);
    step("R2", 16'h0, 0, 4'h4, 0);
    step("R2", 16'h0, 0, 4'h6, 0);
    step("R2", 16'h0, 0, 4'h8, 0);

    // R3: level-high on all lines, acknowledge does not clear
    step("R3", 16'h0, 1, 4'h4, 16'h0000);
    step("R3", 16'h0, 1, 4'h6, 16'h0000);
    step("R3", 16'h0, 1, 4'h8, 16'hFFFF);
    step("R3", 16'h0, 1, 4'hA, 16'h0000);
    step("R3", 16'h0008, 0, 4'hC, 0);
    step("R3", 16'h0008, 1, 4'h0, 16'h0008);
    step("R3", 16'h0008, 0, 4'hC, 0);
    step("R3", 16'h0000, 1, 4'h8, 16'hFFF0);
    step("R3", 16'h0000, 0, 4'hC, 0);

    // R4: single edges; bits 0..7 rising, 8..15 falling
    step("R4", 16'h0300, 1, 4'h8, 16'h00FF);
    step("R4", 16'h0300, 1, 4'h4, 16'hFFFF);
    step("R4", 16'h0302, 0, 4'hC, 0);
    step("R4", 16'h0100, 0, 4'hC, 0);
    step("R4", 16'h0000, 0, 4'hC, 0);

    // R6: acknowledge clears only written lines
    step("R6", 16'h0000, 1, 4'h0, 16'h0002);
    step("R6", 16'h0000, 0, 4'hC, 0);
    step("R6", 16'h0000, 1, 4'h0, 16'hFFFF);
    step("R6", 16'h0000, 0, 4'hC, 0);

    // R8: edge in the acknowledge cycle survives
    step("R8", 16'h0010, 1, 4'h0, 16'h0010);
    step("R8", 16'h0010, 0, 4'hC, 0);

    // R7: acknowledge-and-mask
    step("R7", 16'h0010, 1, 4'h2, 16'h0010);
    step("R7", 16'h0010, 0, 4'hA, 0);
    step("R7", 16'h0010, 0, 4'hC, 0);

    // R5: both edges, polarity ignored
    step("R5", 16'h0000, 1, 4'h6, 16'h000F);
    step("R5", 16'h0000, 1, 4'h0, 16'hFFFF);
    step("R5", 16'h0003, 0, 4'hC, 0);
    step("R5", 16'h0003, 1, 4'h0, 16'h000F);
    step("R5", 16'h0000, 0, 4'hC, 0);

    // R9: masked events latch, show on unmask; level mode discards
    step("R9", 16'h0000, 1, 4'hA, 16'hFFFF);
    step("R9", 16'h0004, 0, 4'hC, 0);
    step("R9", 16'h0004, 1, 4'hA, 16'h0000);
    step("R9", 16'h0004, 0, 4'hC, 0);
    step("R9", 16'h0004, 1, 4'h4, 16'h0000);
    step("R9", 16'h0004, 1, 4'h4, 16'hFFFF);
    step("R9", 16'h0004, 0, 4'hC, 0);

    // R11: inert offsets
    step("R11", 16'h0004, 1, 4'hC, 16'hFFFF);
    step("R11", 16'h0004, 1, 4'hE, 16'hFFFF);
    step("R11", 16'h0004, 1, 4'h5, 16'hFFFF);
    step("R11", 16'h0004, 0, 4'hA, 0);
    step("R11", 16'h0004, 0, 4'h0, 0);
    step("R11", 16'h0004, 0, 4'h2, 0);
    step("R11", 16'h0004, 0, 4'hE, 0);

    // random phase, fixed seed
    void'($urandom(32'd20240611));
    ln = 16'h0004;
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [3:0] a;
      logic [15:0] d;
      op = $urandom_range(0, 11);
      d  = 16'($urandom());
      ln = ln ^ (16'($urandom()) & 16'($urandom()) & 16'($urandom()));
      case (op)
        0, 1, 2: a = 4'hC;
        3: a = 4'h0;
        4: a = 4'h2;
        5: a = 4'h4;
        6: a = 4'h6;
        7: a = 4'h8;
        8: begin a = 4'hA; d = d & 16'($urandom()); end
        9: a = 4'hE;
        10: a = 4'($urandom_range(0, 7) * 2 + 1);
        default: a = 4'hC;
      endcase
      step("R9", ln, (op >= 3 && op <= 10) || op == 2, a, d);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule